// File: doc/BRIEF.md
# Mode-0 Programmable Parallel Port

This block is a byte-wide host peripheral that exposes three 8-bit general-purpose ports, named A, B and C, together with a write-only control register. A host processor reaches the block through a 2-bit register select, an active-low chip select, and active-low read and write strobes. The control word sets, for each port group, whether its pins are driven from an output latch or sampled as inputs. Port C is handled as two 4-bit halves, and each half has its own direction.

Writes pass through a strobe synchronizer, and a latch is loaded once for each strobe assertion. Reads are combinational. An input port returns the live pin levels and an output port returns its latch. A valid direction word also clears every output latch. Control words that do not describe the basic input/output mode are dropped.

Top module: `pario_mode0`

## Requirements
- R1: Register select value 0 addresses port A, 1 addresses port B, 2 addresses port C and 3 addresses the control register. An access happens only while `cs_n` is low together with `rd_n` (read) or `wr_n` (write).
- R2: After reset, every port group is an input (`pa_oe`, `pb_oe` and both `pc_oe` bits are 0) and every output latch holds 0.
- R3: A control write with bit 7 = 1 and bits 6, 5 and 2 all 0 sets the directions, with 1 meaning input. Bit 4 sets port A, bit 1 sets port B, bit 3 sets port C bits 7..4 and bit 0 sets port C bits 3..0. Examples: 0x90 makes A an input and the rest outputs; 0x80 makes everything an output.
- R4: A control write with bit 7 = 0, or with any of bits 6, 5 or 2 set, changes neither the directions nor the latches.
- R5: A valid control write clears all output latches to 0.
- R6: A write to an output port drives that byte onto its output pins. Reading an output port returns its latch.
- R7: Reading a port that is set as an input returns the pin levels at the time of the read. For example, pins at 10010111 read as 0x97.
- R8: Reading port C combines the two halves independently. Each nibble returns its latch if that half is an output, or its pins if that half is an input.
- R9: Reading the control register returns 0xFF. While no read is in progress, `rdata` is 0x00.
- R10: A write takes effect on the third rising clock edge after `cs_n` and `wr_n` are both low. A strobe held low for many cycles performs exactly one write. A write strobe with `cs_n` high has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Register select |
| wdata | input | 8 | Write data from host |
| rdata | output | 8 | Read data to host |
| pa_in | input | 8 | Port A pin levels |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 1 | Port A drives its pins when 1 |
| pb_in | input | 8 | Port B pin levels |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 1 | Port B drives its pins when 1 |
| pc_in | input | 8 | Port C pin levels |
| pc_out | output | 8 | Port C output latch |
| pc_oe | output | 2 | Port C drive enables: bit 1 for bits 7..4, bit 0 for bits 3..0 |

## Verification
The checker watches the read path on every cycle. It checks that the control register reads as 0xFF, that the bus is 0x00 while idle, that input ports read their pins and output ports read their latches, that port C is assembled nibble by nibble, and that an enable which turns on starts from a cleared latch. The bench scenarios are the only place where the control word decoding, the rejection of non-mode words, the three-edge write latency, the single write per long strobe, the writes ignored while unselected and the reset values can be seen.

// File: rtl/pario_pkg.sv
package pario_pkg;
   localparam int BYTE_W = 8;
   localparam int NIB_W  = 4;

   typedef enum logic [1:0] {
      SEL_PA  = 2'd0,
      SEL_PB  = 2'd1,
      SEL_PC  = 2'd2,
      SEL_CTL = 2'd3
   } reg_sel_e;

   // control word bit positions (decoded behaviour)
   localparam int CW_DEFINE = 7;
   localparam int CW_DIR_A  = 4;
   localparam int CW_DIR_CU = 3;
   localparam int CW_DIR_B  = 1;
   localparam int CW_DIR_CL = 0;
   // bits that must be zero for basic I/O mode
   localparam logic [BYTE_W-1:0] CW_MODE_MASK = 8'b0110_0100;
endpackage

// File: rtl/pario_strobe_sync.sv
module pario_strobe_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe_async,
   output logic pulse
);
   if (STAGES < 2) begin : g_bad_stages
      $error("pario_strobe_sync: STAGES must be at least 2");
   end

   logic [STAGES:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[STAGES-1:0], strobe_async};
   end

   // one cycle pulse on the rising edge of the synchronized strobe
   assign pulse = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/pario_slice.sv
module pario_slice #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ld,
   input  logic         def,
   input  logic         def_in,
   input  logic [W-1:0] wd,
   input  logic [W-1:0] pin_in,
   output logic [W-1:0] pin_out,
   output logic         oe,
   output logic [W-1:0] rd_val
);
   if (W < 1) begin : g_bad_w
      $error("pario_slice: W must be positive");
   end

   logic         dir_in;
   logic [W-1:0] lat;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_in <= 1'b1;
         lat    <= '0;
      end else if (def) begin
         dir_in <= def_in;
         lat    <= '0;
      end else if (ld) begin
         lat    <= wd;
      end
   end

   assign pin_out = lat;
   assign oe      = ~dir_in;
   assign rd_val  = dir_in ? pin_in : lat;
endmodule

// File: rtl/pario_mode0.sv
module pario_mode0 import pario_pkg::*; #(
   parameter int              SYNC_STAGES = 2,
   parameter logic [7:0]      RD_CTRL_VAL = 8'hFF
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cs_n,
   input  logic       rd_n,
   input  logic       wr_n,
   input  logic [1:0] addr,
   input  logic [7:0] wdata,
   output logic [7:0] rdata,
   input  logic [7:0] pa_in,
   output logic [7:0] pa_out,
   output logic       pa_oe,
   input  logic [7:0] pb_in,
   output logic [7:0] pb_out,
   output logic       pb_oe,
   input  logic [7:0] pc_in,
   output logic [7:0] pc_out,
   output logic [1:0] pc_oe
);
   localparam int HALVES = BYTE_W / NIB_W;

   if (SYNC_STAGES < 2 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("pario_mode0: SYNC_STAGES must be 2 to 4");
   end

   reg_sel_e sel;
   logic     wr_pulse, rd_act;
   logic     def_ok, ld_a, ld_b, ld_c;
   logic [BYTE_W-1:0] rd_a, rd_b, rd_c;

   assign sel    = reg_sel_e'(addr);
   assign rd_act = ~cs_n & ~rd_n;

   pario_strobe_sync #(.STAGES(SYNC_STAGES)) u_wsync (
      .clk          (clk),
      .rst_n        (rst_n),
      .strobe_async (~cs_n & ~wr_n),
      .pulse        (wr_pulse)
   );

   assign def_ok = wr_pulse && (sel == SEL_CTL) && wdata[CW_DEFINE]
                   && ((wdata & CW_MODE_MASK) == '0);
   assign ld_a   = wr_pulse && (sel == SEL_PA);
   assign ld_b   = wr_pulse && (sel == SEL_PB);
   assign ld_c   = wr_pulse && (sel == SEL_PC);

   pario_slice #(.W(BYTE_W)) u_pa (
      .clk(clk), .rst_n(rst_n), .ld(ld_a), .def(def_ok),
      .def_in(wdata[CW_DIR_A]), .wd(wdata), .pin_in(pa_in),
      .pin_out(pa_out), .oe(pa_oe), .rd_val(rd_a)
   );

   pario_slice #(.W(BYTE_W)) u_pb (
      .clk(clk), .rst_n(rst_n), .ld(ld_b), .def(def_ok),
      .def_in(wdata[CW_DIR_B]), .wd(wdata), .pin_in(pb_in),
      .pin_out(pb_out), .oe(pb_oe), .rd_val(rd_b)
   );

   // port C: independent nibbles, upper half direction in bit 3, lower in bit 0
   for (genvar h = 0; h < HALVES; h++) begin : g_pc
      localparam int DIRB = (h == 0) ? CW_DIR_CL : CW_DIR_CU;
      pario_slice #(.W(NIB_W)) u_pc (
         .clk     (clk),
         .rst_n   (rst_n),
         .ld      (ld_c),
         .def     (def_ok),
         .def_in  (wdata[DIRB]),
         .wd      (wdata[h*NIB_W +: NIB_W]),
         .pin_in  (pc_in[h*NIB_W +: NIB_W]),
         .pin_out (pc_out[h*NIB_W +: NIB_W]),
         .oe      (pc_oe[h]),
         .rd_val  (rd_c[h*NIB_W +: NIB_W])
      );
   end

   always_comb begin
      rdata = '0;
      if (rd_act) begin
         unique case (sel)
            SEL_PA:  rdata = rd_a;
            SEL_PB:  rdata = rd_b;
            SEL_PC:  rdata = rd_c;
            SEL_CTL: rdata = RD_CTRL_VAL;
            default: rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/pario_mode0_chk.sv
module pario_mode0_chk #(
   parameter logic [7:0] RD_CTRL_VAL = 8'hFF
) (
   input logic       clk,
   input logic       rst_n,
   input logic       cs_n,
   input logic       rd_n,
   input logic [1:0] addr,
   input logic [7:0] rdata,
   input logic [7:0] pa_in,
   input logic [7:0] pa_out,
   input logic       pa_oe,
   input logic [7:0] pb_out,
   input logic       pb_oe,
   input logic [7:0] pc_in,
   input logic [7:0] pc_out,
   input logic [1:0] pc_oe
);
   AST_CTL_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && !rd_n && addr == 2'd3) |-> rdata == RD_CTRL_VAL); // R9
   AST_IDLE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n || rd_n) |-> rdata == 8'h00); // R9
   AST_PA_IN_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && !rd_n && addr == 2'd0 && !pa_oe) |-> rdata == pa_in); // R7
   AST_PB_OUT_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && !rd_n && addr == 2'd1 && pb_oe) |-> rdata == pb_out); // R6
   AST_PC_LOW_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && !rd_n && addr == 2'd2) |->
         rdata[3:0] == (pc_oe[0] ? pc_out[3:0] : pc_in[3:0])); // R8
   AST_PC_HIGH_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && !rd_n && addr == 2'd2) |->
         rdata[7:4] == (pc_oe[1] ? pc_out[7:4] : pc_in[7:4])); // R8
   AST_DEF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pa_oe) |-> pa_out == 8'h00); // R5
endmodule

bind pario_mode0 pario_mode0_chk #(.RD_CTRL_VAL(RD_CTRL_VAL)) u_chk (.*);

// File: tb/sim_pario_mode0.sv
module sim_pario_mode0;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
   logic [1:0] addr = '0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic [7:0] pa_in = '0, pb_in = '0, pc_in = '0;
   logic [7:0] pa_out, pb_out, pc_out;
   logic       pa_oe, pb_oe;
   logic [1:0] pc_oe;
   int n_chk = 0, n_fail = 0;

   always #10 clk = ~clk; // 50 MHz

   pario_mode0 u0 (.*);

   localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_PIN = 2'd2;
   localparam int NV = 26;
   // {op, addr, data, expected, requirement}
   localparam logic [23:0] VEC [NV] = '{
      {OP_WR,  2'd3, 8'h90, 8'h00, 4'd3},  // R3 A in, rest out
      {OP_PIN, 2'd0, 8'h97, 8'h00, 4'd7},
      {OP_RD,  2'd0, 8'h00, 8'h97, 4'd7},  // R7 live pins
      {OP_WR,  2'd1, 8'h0F, 8'h00, 4'd6},
      {OP_RD,  2'd1, 8'h00, 8'h0F, 4'd6},  // R6 latch read
      {OP_WR,  2'd2, 8'hA5, 8'h00, 4'd6},
      {OP_RD,  2'd2, 8'h00, 8'hA5, 4'd1},  // R1 select 2 is port C
      {OP_RD,  2'd3, 8'h00, 8'hFF, 4'd9},  // R9 control read
      {OP_WR,  2'd3, 8'h80, 8'h00, 4'd5},
      {OP_RD,  2'd1, 8'h00, 8'h00, 4'd5},  // R5 latch cleared
      {OP_WR,  2'd0, 8'h3C, 8'h00, 4'd3},
      {OP_RD,  2'd0, 8'h00, 8'h3C, 4'd3},  // R3 A now output
      {OP_WR,  2'd3, 8'h89, 8'h00, 4'd3},  // both C halves in
      {OP_PIN, 2'd0, 8'h5A, 8'h00, 4'd7},
      {OP_RD,  2'd2, 8'h00, 8'h5A, 4'd7},  // R7
      {OP_WR,  2'd2, 8'hFF, 8'h00, 4'd8},
      {OP_RD,  2'd2, 8'h00, 8'h5A, 4'd8},  // R8 pins still read
      {OP_WR,  2'd3, 8'h81, 8'h00, 4'd8},  // C upper out, lower in
      {OP_RD,  2'd2, 8'h00, 8'h0A, 4'd8},  // R8
      {OP_WR,  2'd2, 8'hC3, 8'h00, 4'd8},
      {OP_RD,  2'd2, 8'h00, 8'hCA, 4'd8},  // R8 mixed halves
      {OP_WR,  2'd3, 8'h24, 8'h00, 4'd4},  // bit7 = 0
      {OP_RD,  2'd2, 8'h00, 8'hCA, 4'd4},  // R4
      {OP_WR,  2'd3, 8'hC0, 8'h00, 4'd4},  // bit6 set
      {OP_WR,  2'd3, 8'h84, 8'h00, 4'd4},  // bit2 set
      {OP_RD,  2'd2, 8'h00, 8'hCA, 4'd4}   // R4
   };

   task automatic check(input int req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL R%0d: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wdata = d; cs_n = 1'b0; wr_n = 1'b0;
      repeat (6) @(negedge clk);
      cs_n = 1'b1; wr_n = 1'b1;
      repeat (2) @(negedge clk);
   endtask

   task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      addr = a; cs_n = 1'b0; rd_n = 1'b0;
      @(negedge clk);
      d = rdata;
      cs_n = 1'b1; rd_n = 1'b1;
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
   end

   initial begin
      logic [7:0] r;
      // R2 reset state
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(2, {pa_oe, pb_oe, pc_oe, 4'b0}, 8'h00);        // R2 all inputs
      check(2, pa_out | pb_out | pc_out, 8'h00);           // R2 latches clear
      check(9, rdata, 8'h00);                              // R9 idle bus

      for (int i = 0; i < NV; i++) begin
         case (VEC[i][23:22])
            OP_WR:  bus_wr(VEC[i][21:20], VEC[i][19:12]);
            OP_PIN: begin
               @(negedge clk);
               pa_in = VEC[i][19:12]; pb_in = VEC[i][19:12]; pc_in = VEC[i][19:12];
            end
            default: begin
               bus_rd(VEC[i][21:20], r);
               check(int'(VEC[i][3:0]), r, VEC[i][11:4]);
            end
         endcase
      end

      // R3 pin-level view after all-output word
      bus_wr(2'd3, 8'h80);
      bus_wr(2'd0, 8'h0F);
      check(6, pa_out, 8'h0F);                             // R6 pins driven
      check(3, {pa_oe, pb_oe, pc_oe, 4'b0}, 8'hF0);        // R3 all outputs

      // R10 latency: third edge after strobe
      @(negedge clk);
      addr = 2'd0; wdata = 8'h66; cs_n = 1'b0; wr_n = 1'b0;
      @(negedge clk); @(negedge clk);
      check(10, pa_out, 8'h0F);                            // R10 not yet
      @(negedge clk);
      check(10, pa_out, 8'h66);                            // R10 updated
      wdata = 8'h77;                                       // long strobe, data changes
      repeat (8) @(negedge clk);
      cs_n = 1'b1; wr_n = 1'b1;
      repeat (2) @(negedge clk);
      check(10, pa_out, 8'h66);                            // R10 single write

      // R10 / R1 write without chip select
      @(negedge clk);
      addr = 2'd0; wdata = 8'hEE; wr_n = 1'b0;
      repeat (6) @(negedge clk);
      wr_n = 1'b1;
      repeat (2) @(negedge clk);
      check(1, pa_out, 8'h66);                             // R1 unselected ignored
      rd_n = 1'b0; addr = 2'd0;
      @(negedge clk);
      check(1, rdata, 8'h00);                              // R1 read needs cs_n
      rd_n = 1'b1;

      // R2 reset mid-run
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(2, {pa_oe, pb_oe, pc_oe, 4'b0}, 8'h00);
      check(2, pa_out, 8'h00);

      finish_run();
   end
endmodule